// File: doc/BRIEF.md
# History Buffer Undo Log

This block keeps the register file precise for a pipeline that writes results as soon as an instruction finishes, even when instructions finish out of order. Each instruction reserves a slot at decode, in program order. When it completes, the block copies the destination's current contents into that slot and writes the new result straight into the register file. Ordinary operand reads go only to the register file and never search the log.

When the oldest slot has finished cleanly, it is dropped, one per cycle. Two events trigger recovery. The first is an oldest slot that finished with an exception. The second is a branch misprediction reported against a live slot. In either case the block walks from the youngest slot backward and restores one saved value per cycle. An exception undoes every slot. A misprediction undoes only the slots younger than the branch. A one-cycle done pulse marks the end of a walk.

The log assumes the following about its environment. Completions that target the same register arrive in program order. A misprediction names a live slot.

Top module: `undo_log`

## Requirements
- R1: After reset the log is empty, `busy` and `doneP` are 0, `allocReady` is 1 and every register reads 0.
- R2: Slot numbers are handed out consecutively modulo 8, starting at 0 after reset. `allocReady` is 0 while 8 slots are outstanding.
- R3: A clean completion of a slot with a destination makes `rdData` return the new value from the next cycle on, without waiting for retirement. The read port returns register file contents only.
- R4: A completion with `cmplExc`=1 leaves the register file unchanged.
- R5: Finished clean slots leave from the oldest end, one per clock edge. The oldest one leaves at the edge after it becomes finished. Their writes persist, and the freed slots can be reserved again.
- R6: An oldest slot finished with an exception starts a walk in the next cycle. The walk takes one cycle per occupied slot, restores every saved value youngest first and empties the log. The next slot handed out is the excepting slot's number.
- R7: A misprediction on slot b undoes only the slots younger than b, one cycle each. Slot b and older slots keep their writes. The next slot handed out is b+1 modulo 8.
- R8: A slot without a destination, not yet completed, or completed with an exception changes no register during a walk, yet still takes its cycle.
- R9: In the cycle a walk is started and while it runs, `allocReady` is 0, completions are ignored and no register other than a restore changes.
- R10: `doneP` is high for exactly one cycle, the cycle after the last restore. A misprediction with no younger slots raises `doneP` in the next cycle and never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Reserve a slot this cycle |
| allocHasDst | input | 1 | The instruction writes a register |
| allocDst | input | 4 | Destination register number |
| allocReady | output | 1 | A reservation is accepted this cycle |
| allocSlot | output | 3 | Slot number given to the reservation |
| cmplValid | input | 1 | A slot finishes this cycle |
| cmplSlot | input | 3 | Slot that finishes |
| cmplExc | input | 1 | The finishing instruction raised an exception |
| cmplData | input | 32 | Result value |
| mispValid | input | 1 | A branch was mispredicted |
| mispSlot | input | 3 | Slot of the mispredicted branch |
| busy | output | 1 | A recovery walk is in progress |
| doneP | output | 1 | One-cycle pulse after recovery ends |
| rdAddr | input | 4 | Register read address |
| rdData | output | 32 | Register read data (combinational) |

## Verification
A sweep covers every log depth from 1 to 8 against every branch position inside that depth. Slots complete youngest first, so each case tells a correct backward walk and cycle count from one that undoes too much or too little. An exception case fills the log with a mix of writing slots, slots without a destination, an excepting slot and an unfinished slot. It also pokes completions and reservations during the walk, which shows whether skipped slots still take a cycle and whether blocked inputs leak in. A final case fills and drains the log, which separates correct retirement timing and full detection from off-by-one pointer handling.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;
  parameter int SLOTS = 8;
  parameter int REGS  = 16;
  parameter int DW    = 32;
  localparam int SW = $clog2(SLOTS);
  localparam int PW = SW + 1;
  localparam int RW = $clog2(REGS);

  // strobes from control to datapath
  typedef struct packed {
    logic          alloc;
    logic [SW-1:0] allocIdx;
    logic          cmpl;
    logic          retire;
    logic [SW-1:0] headIdx;
    logic          undo;
    logic [SW-1:0] undoIdx;
  } strobe_t;
endpackage

// File: rtl/undo_log_ctrl.sv
module undo_log_ctrl
  import undo_log_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocValid,
  input  logic          cmplValid,
  input  logic          mispValid,
  input  logic [SW-1:0] mispSlot,
  input  logic          headComp,
  input  logic          headExc,
  output logic          allocReady,
  output logic [SW-1:0] allocSlot,
  output logic          busy,
  output logic          doneP,
  output strobe_t       strb
);
  logic [PW-1:0] headPtr, tailPtr, stopPtr;
  logic [PW-1:0] occ, lastPtr, mispPtr, mispNext;
  logic [SW-1:0] mispOff;
  logic walking, doneQ, walkExc;
  logic full, empty, excStart, mispStart, quiet;

  always_comb begin
    occ       = tailPtr - headPtr;
    full      = (occ == PW'(SLOTS));
    empty     = (occ == '0);
    lastPtr   = tailPtr - PW'(1);
    mispOff   = mispSlot - headPtr[SW-1:0];
    mispPtr   = headPtr + {1'b0, mispOff};
    mispNext  = mispPtr + PW'(1);
    excStart  = !walking && !empty && headComp && headExc;
    mispStart = !walking && !excStart && mispValid;
    quiet     = walking || excStart || mispStart;
    allocReady = !quiet && !full;

    strb.alloc    = allocValid && allocReady;
    strb.allocIdx = tailPtr[SW-1:0];
    strb.cmpl     = cmplValid && !quiet;
    strb.retire   = !quiet && !empty && headComp && !headExc;
    strb.headIdx  = headPtr[SW-1:0];
    strb.undo     = walking;
    strb.undoIdx  = lastPtr[SW-1:0];
  end

  assign allocSlot = tailPtr[SW-1:0];
  assign busy      = walking;
  assign doneP     = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      stopPtr <= '0;
      walking <= 1'b0;
      walkExc <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (walking) begin
        tailPtr <= lastPtr;
        if (lastPtr == stopPtr) begin
          walking <= 1'b0;
          doneQ   <= 1'b1;
        end
      end else if (excStart) begin
        stopPtr <= headPtr;
        walking <= 1'b1;
        walkExc <= 1'b1;
      end else if (mispStart) begin
        stopPtr <= mispNext;
        walkExc <= 1'b0;
        if (tailPtr == mispNext) doneQ   <= 1'b1;
        else                     walking <= 1'b1;
      end else begin
        if (strb.alloc)  tailPtr <= tailPtr + PW'(1);
        if (strb.retire) headPtr <= headPtr + PW'(1);
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occ <= PW'(SLOTS)); // R2
  AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(walking) |-> doneQ); // R10
  AST_EXC_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(walking) && walkExc) |-> (tailPtr == headPtr)); // R6
  AST_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    walking |=> $stable(headPtr)); // R9
endmodule

// File: rtl/undo_log_dp.sv
module undo_log_dp
  import undo_log_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic          allocHasDst,
  input  logic [RW-1:0] allocDst,
  input  logic [SW-1:0] cmplSlot,
  input  logic          cmplExc,
  input  logic [DW-1:0] cmplData,
  input  logic [RW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          headComp,
  output logic          headExc
);
  logic [SLOTS-1:0] validQ, compQ, excQ, dstEnQ;
  logic [RW-1:0]    dstQ [SLOTS];
  logic [DW-1:0]    oldQ [SLOTS];
  logic [DW-1:0]    rf   [REGS];

  logic          cmplWr, undoWr, rfWe;
  logic [RW-1:0] rfWa;
  logic [DW-1:0] rfWd;

  always_comb begin
    cmplWr = strb.cmpl && validQ[cmplSlot] && dstEnQ[cmplSlot] && !cmplExc;
    undoWr = strb.undo && validQ[strb.undoIdx] && compQ[strb.undoIdx]
             && !excQ[strb.undoIdx] && dstEnQ[strb.undoIdx];
    rfWe   = cmplWr || undoWr;
    rfWa   = undoWr ? dstQ[strb.undoIdx] : dstQ[cmplSlot];
    rfWd   = undoWr ? oldQ[strb.undoIdx] : cmplData;
  end

  assign rdData   = rf[rdAddr];
  assign headComp = validQ[strb.headIdx] && compQ[strb.headIdx];
  assign headExc  = excQ[strb.headIdx];

  // slot bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      compQ  <= '0;
      excQ   <= '0;
      dstEnQ <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        dstQ[s] <= '0;
        oldQ[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (strb.alloc && strb.allocIdx == SW'(s)) begin
          validQ[s] <= 1'b1;
          compQ[s]  <= 1'b0;
          excQ[s]   <= 1'b0;
          dstEnQ[s] <= allocHasDst;
          dstQ[s]   <= allocDst;
        end else if ((strb.retire && strb.headIdx == SW'(s)) ||
                     (strb.undo && strb.undoIdx == SW'(s))) begin
          validQ[s] <= 1'b0;
        end else if (strb.cmpl && cmplSlot == SW'(s) && validQ[s]) begin
          compQ[s] <= 1'b1;
          excQ[s]  <= cmplExc;
          if (cmplWr) oldQ[s] <= rf[dstQ[s]];
        end
      end
    end
  end

  // register file, one write port shared by completion and restore
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REGS; r++) rf[r] <= '0;
    end else if (rfWe) begin
      rf[rfWa] <= rfWd;
    end
  end

  AST_UNDO_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.undo |-> validQ[strb.undoIdx]); // R6
  AST_RETIRE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    strb.retire |-> (validQ[strb.headIdx] && compQ[strb.headIdx] && !excQ[strb.headIdx])); // R5
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cmpl && strb.undo)); // R9
  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |-> !validQ[strb.allocIdx]); // R2
endmodule

// File: rtl/undo_log.sv
module undo_log
  import undo_log_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocValid,
  input  logic          allocHasDst,
  input  logic [RW-1:0] allocDst,
  output logic          allocReady,
  output logic [SW-1:0] allocSlot,
  input  logic          cmplValid,
  input  logic [SW-1:0] cmplSlot,
  input  logic          cmplExc,
  input  logic [DW-1:0] cmplData,
  input  logic          mispValid,
  input  logic [SW-1:0] mispSlot,
  output logic          busy,
  output logic          doneP,
  input  logic [RW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  strobe_t strb;
  logic    headComp, headExc;

  undo_log_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .cmplValid(cmplValid),
    .mispValid(mispValid), .mispSlot(mispSlot), .headComp(headComp),
    .headExc(headExc), .allocReady(allocReady), .allocSlot(allocSlot),
    .busy(busy), .doneP(doneP), .strb(strb)
  );

  undo_log_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .allocHasDst(allocHasDst),
    .allocDst(allocDst), .cmplSlot(cmplSlot), .cmplExc(cmplExc),
    .cmplData(cmplData), .rdAddr(rdAddr), .rdData(rdData),
    .headComp(headComp), .headExc(headExc)
  );
endmodule

// File: tb/undo_log_bench.sv
`timescale 1ns/1ps
module undo_log_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, allocHasDst = 0, cmplValid = 0, cmplExc = 0, mispValid = 0;
  logic [3:0] allocDst = 0, rdAddr = 0;
  logic [2:0] cmplSlot = 0, mispSlot = 0;
  logic [31:0] cmplData = 0;
  logic allocReady, busy, doneP;
  logic [2:0] allocSlot;
  logic [31:0] rdData;

  int checks = 0, failures = 0, nextSlot = 0;
  logic [31:0] model [16];
  logic [31:0] snap [16];

  always #4 clk = ~clk;

  undo_log u_undo_log (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocHasDst(allocHasDst),
    .allocDst(allocDst), .allocReady(allocReady), .allocSlot(allocSlot),
    .cmplValid(cmplValid), .cmplSlot(cmplSlot), .cmplExc(cmplExc),
    .cmplData(cmplData), .mispValid(mispValid), .mispSlot(mispSlot),
    .busy(busy), .doneP(doneP), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input int a, output logic [31:0] v);
    rdAddr = 4'(a);
    #0.1;
    v = rdData;
  endtask

  task automatic cmpRegs(input string req);
    logic [31:0] v;
    for (int r = 0; r < 16; r++) begin
      readReg(r, v);
      chk(req, v, model[r]);
    end
  endtask

  task automatic doAlloc(input bit hd, input int dst, output int id);
    allocValid = 1; allocHasDst = hd; allocDst = 4'(dst);
    #0.1;
    chk("R2 ready", {31'd0, allocReady}, 32'd1);
    chk("R2 slot", {29'd0, allocSlot}, 32'(nextSlot));
    id = int'(allocSlot);
    tick();
    allocValid = 0;
    nextSlot = (nextSlot + 1) % 8;
  endtask

  task automatic doCmpl(input int slot, input bit exc, input logic [31:0] data);
    cmplValid = 1; cmplSlot = 3'(slot); cmplExc = exc; cmplData = data;
    tick();
    cmplValid = 0; cmplExc = 0;
  endtask

  // counts busy cycles until doneP, then checks the pulse falls
  task automatic waitDone(output int busyCnt);
    bit got = 0;
    busyCnt = 0;
    for (int c = 0; c < 24; c++) begin
      if (doneP) begin got = 1; break; end
      if (busy) begin
        busyCnt++;
        chk("R9 ready during walk", {31'd0, allocReady}, 32'd0);
      end
      tick();
    end
    chk("R10 done seen", {31'd0, got}, 32'd1);
    chk("R10 busy low at done", {31'd0, busy}, 32'd0);
    tick();
    chk("R10 done one cycle", {31'd0, doneP}, 32'd0);
  endtask

  initial begin
    #(8.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int iter = 0;
    int bc;
    logic [31:0] v;
    for (int r = 0; r < 16; r++) model[r] = '0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", {31'd0, allocReady}, 32'd1);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, doneP}, 32'd0);
    chk("R1 slot", {29'd0, allocSlot}, 32'd0);
    cmpRegs("R1 regs");

    // R7/R10/R3 sweep: every depth and branch position
    for (int n = 1; n <= 8; n++) begin
      for (int b = 0; b < n; b++) begin
        int ids[8];
        int dsts[8];
        logic [31:0] olds[8];
        int m;
        for (int k = 0; k < n; k++) begin
          dsts[k] = (k + iter) % 16;
          doAlloc(k != 0, dsts[k], ids[k]);
        end
        for (int k = n - 1; k >= 1; k--) begin
          logic [31:0] val;
          val = 32'(iter * 256 + k + 1);
          olds[k] = model[dsts[k]];
          model[dsts[k]] = val;
          doCmpl(ids[k], 0, val);
          readReg(dsts[k], v);
          chk("R3 immediate write", v, val);
        end
        mispValid = 1; mispSlot = 3'(ids[b]);
        tick();
        mispValid = 0;
        m = n - 1 - b;
        if (m == 0) chk("R10 no busy on empty walk", {31'd0, busy}, 32'd0);
        waitDone(bc);
        chk("R7 walk cycles", 32'(bc), 32'(m));
        for (int k = n - 1; k > b; k--) model[dsts[k]] = olds[k];
        cmpRegs("R7 regs after rewind");
        nextSlot = (ids[b] + 1) % 8;
        chk("R7 next slot", {29'd0, allocSlot}, 32'(nextSlot));
        doCmpl(ids[0], 0, 32'h0);
        repeat (b + 2) tick();
        chk("R5 drained", {31'd0, allocReady}, 32'd1);
        iter++;
      end
    end

    // R6/R8/R4/R9 exception walk on a full log
    begin
      int ids[8];
      for (int r = 0; r < 16; r++) snap[r] = model[r];
      for (int k = 0; k < 8; k++) doAlloc(k != 3, (k == 0) ? 2 : 8 + k, ids[k]);
      chk("R2 full", {31'd0, allocReady}, 32'd0);
      for (int k = 7; k >= 1; k--) begin
        if (k == 6) continue;
        if (k == 5) begin
          doCmpl(ids[k], 1, 32'h5555_0000);
          readReg(13, v);
          chk("R4 exc no write", v, model[13]);
        end else if (k == 3) begin
          doCmpl(ids[k], 0, 32'h3333_0000);
        end else begin
          model[8 + k] = 32'hA000_0000 + 32'(k);
          doCmpl(ids[k], 0, model[8 + k]);
          readReg(8 + k, v);
          chk("R3 write before retire", v, model[8 + k]);
        end
      end
      doCmpl(ids[0], 1, 32'h0BAD_0000);
      // walk starts: inputs must be ignored
      cmplValid = 1; cmplSlot = 3'(ids[6]); cmplData = 32'hDEAD_0000; allocValid = 1;
      #0.1;
      chk("R9 ready at walk start", {31'd0, allocReady}, 32'd0);
      tick();
      chk("R6 busy", {31'd0, busy}, 32'd1);
      cmplData = 32'hBEEF_0000;
      #0.1;
      chk("R9 ready while busy", {31'd0, allocReady}, 32'd0);
      tick();
      cmplValid = 0; allocValid = 0;
      waitDone(bc);
      chk("R8 walk takes every slot", 32'(bc + 1), 32'd8);
      for (int r = 0; r < 16; r++) model[r] = snap[r];
      cmpRegs("R6 regs restored");
      nextSlot = ids[0];
      chk("R6 next slot", {29'd0, allocSlot}, 32'(nextSlot));
    end

    // R5 retirement order and refill
    begin
      int ids[8];
      int tmp;
      for (int k = 0; k < 8; k++) doAlloc(1, k, ids[k]);
      for (int k = 7; k >= 1; k--) begin
        model[k] = 32'hC000_0000 + 32'(k);
        doCmpl(ids[k], 0, model[k]);
      end
      chk("R5 full before head", {31'd0, allocReady}, 32'd0);
      model[0] = 32'hC000_0000;
      doCmpl(ids[0], 0, model[0]);
      chk("R5 no retire same edge", {31'd0, allocReady}, 32'd0);
      tick();
      chk("R5 one slot freed", {31'd0, allocReady}, 32'd1);
      repeat (8) tick();
      cmpRegs("R5 writes persist");
      for (int k = 0; k < 8; k++) doAlloc(0, 0, tmp);
      chk("R2 full again", {31'd0, allocReady}, 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule